// File: doc/BRIEF.md
# LIN Request Handshake Controller

This block keeps the request bits that software uses to drive a LIN protocol controller. It covers header send, abort, data send, data discard and wake-up. It also holds the configuration bit that decides how an identifier parity error is handled. Software sets a request by writing a 1 through a single-cycle write port. Each request has its own rule for when such a write is accepted. Operating mode, the header-received flag and the filter-match flag all take part in that rule.

A separate bit-level frame engine reports its progress to this block through single-cycle status strobes. Those strobes are what clear the requests. On the cycle a request becomes set, the block sends the engine a one-cycle command pulse. In master mode the block sets the data-send request itself once a header for a transmit frame has finished. While a wake-up is pending, the block holds the wake-up character and tells the engine to skip bit-error checking.

Top module: `lin_req_ctrl`

## Requirements
- R1: After reset, all request bits and the parity configuration bit read 0, and every command pulse and acknowledge output is low.
- R2: A write of 1 to an accepted request bit sets it on that clock edge. Its command output is high for exactly the one cycle after that edge. Writes of 0 leave requests unchanged. A hardware clear in the same cycle wins over a set. Readback layout: bit 0 header, bit 1 abort, bit 2 data send, bit 3 discard, bit 4 wake-up, bit 5 parity configuration.
- R3: The header request is set by a write unless UART mode is active. It clears on header-done or abort-done. While UART mode is active, the header, data-send and discard requests are held at 0.
- R4: In slave mode, a data-send write is accepted only while the header-received flag is 1. The request clears on response-done, abort-done or error.
- R5: In master mode, software writes to the data-send bit are ignored. Hardware sets the bit when header-done arrives while the header request is pending and the buffer direction input is 1 (transmit). It stays 0 when the direction input is 0.
- R6: A discard write is accepted in master mode at any time. In slave mode it is accepted only when the header-received flag is 1 and the filter-match flag is 0. The discard request clears when the engine reports idle.
- R7: A wake-up write is ignored in sleep mode. On acceptance, the block captures data byte 0 as the wake-up character and holds it until the next wake-up request. Bit-error checking enable is 0 while the request is pending. The request clears on wake-done.
- R8: The abort request is accepted in every mode, UART included. Abort-done clears the abort, header, data-send and wake-up requests.
- R9: The parity configuration bit takes the written value (0 or 1) only in initialization mode. Writes in any other mode leave it unchanged.
- R10: The return-to-idle output is high exactly when an identifier parity error strobe arrives while the configuration bit is 1.
- R11: One cycle after a completion strobe that finishes a pending request, the done acknowledge pulses. If abort-done arrives in the same cycle, only the abort acknowledge pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write data (layout in R2) |
| mode_init | input | 1 | Initialization mode |
| mode_sleep | input | 1 | Sleep mode |
| mode_master | input | 1 | 1 master, 0 slave |
| mode_uart | input | 1 | UART mode |
| hdr_rcvd | input | 1 | Header-received flag |
| id_match | input | 1 | Identifier matched a filter |
| buf_dir_tx | input | 1 | Buffer direction, 1 transmit |
| buf_data0 | input | DATA_W | Buffer data byte 0 |
| eng_hdr_done | input | 1 | Header finished strobe |
| eng_rsp_done | input | 1 | Response finished strobe |
| eng_abort_done | input | 1 | Abort took effect strobe |
| eng_err | input | 1 | Frame error strobe |
| eng_idle | input | 1 | Engine back in idle strobe |
| eng_wake_done | input | 1 | Wake-up character sent strobe |
| eng_par_err | input | 1 | Identifier parity error strobe |
| rd_data | output | 6 | Readback of requests and configuration |
| cmd_hdr | output | 1 | Start header pulse |
| cmd_abort | output | 1 | Abort pulse |
| cmd_dtx | output | 1 | Start data send pulse |
| cmd_discard | output | 1 | Discard pulse |
| cmd_wake | output | 1 | Start wake-up pulse |
| wake_char | output | DATA_W | Captured wake-up character |
| bit_chk_en | output | 1 | Bit-error checking enable |
| fsm_to_idle | output | 1 | Force protocol machine to idle |
| ack_done | output | 1 | Request completed pulse |
| ack_abort | output | 1 | Request aborted pulse |

## Verification
A vector table steps through one accepted write and one rejected write for each request. The rejected writes come from sleep mode, UART mode, slave mode with the header flag low, slave mode with a filter match, and master mode. Between them, the table fires the strobe that clears each request. This separates the per-bit gating rules from the per-bit clear sources.

The master sequence is run twice, once with the direction input at 1 and once at 0. This separates the hardware set from an unconditional one. Directed tests fire a completion strobe and abort-done in the same cycle to expose acknowledge priority. They also change data byte 0 after a wake-up has been accepted, which shows the character was captured rather than passed through. Finally they toggle the configuration bit in and out of initialization mode to test the parity response.

// File: rtl/lin_req_pkg.sv
package lin_req_pkg;
  localparam int unsigned NREQ     = 5;
  localparam int unsigned REG_W    = NREQ + 1;
  localparam int unsigned IDX_HDR  = 0;
  localparam int unsigned IDX_ABRT = 1;
  localparam int unsigned IDX_DTX  = 2;
  localparam int unsigned IDX_DISC = 3;
  localparam int unsigned IDX_WAKE = 4;
  localparam int unsigned IDX_PCFG = 5;

  typedef struct packed {
    logic hdr_done;
    logic rsp_done;
    logic abort_done;
    logic err;
    logic idle;
    logic wake_done;
  } eng_stat_t;
endpackage

// File: rtl/lin_req_bit.sv
module lin_req_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic cmd_o
);
  logic q_d, cmd_d;
  logic q_r, cmd_r;

  always_comb begin
    q_d   = q_r;
    cmd_d = 1'b0;
    if (clr_i) begin
      q_d = 1'b0;
    end else if (set_i) begin
      q_d   = 1'b1;
      cmd_d = ~q_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= 1'b0;
      cmd_r <= 1'b0;
    end else begin
      q_r   <= q_d;
      cmd_r <= cmd_d;
    end
  end

  assign q_o   = q_r;
  assign cmd_o = cmd_r;

  // R2: a command pulse only marks a request that is now held
  a_r2_cmd_marks_set: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_r |-> q_r);
  // R2: command lasts a single cycle
  a_r2_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_r |=> !cmd_r);
endmodule

// File: rtl/lin_req_rules.sv
module lin_req_rules
  import lin_req_pkg::*;
(
  input  logic            wr_en,
  input  logic [NREQ-1:0] wr_req,
  input  logic            mode_sleep,
  input  logic            mode_master,
  input  logic            mode_uart,
  input  logic            hdr_rcvd,
  input  logic            id_match,
  input  logic            buf_dir_tx,
  input  eng_stat_t       stat,
  input  logic [NREQ-1:0] q,
  output logic [NREQ-1:0] set,
  output logic [NREQ-1:0] clr
);
  logic [NREQ-1:0] wr_set;

  always_comb begin
    wr_set = wr_en ? wr_req : '0;

    set[IDX_HDR]  = wr_set[IDX_HDR] & ~mode_uart;
    set[IDX_ABRT] = wr_set[IDX_ABRT];
    set[IDX_DTX]  = ~mode_uart &
                    (mode_master ? (stat.hdr_done & q[IDX_HDR] & buf_dir_tx)
                                 : (wr_set[IDX_DTX] & hdr_rcvd));
    set[IDX_DISC] = wr_set[IDX_DISC] & ~mode_uart &
                    (mode_master | (hdr_rcvd & ~id_match));
    set[IDX_WAKE] = wr_set[IDX_WAKE] & ~mode_sleep;

    clr[IDX_HDR]  = stat.hdr_done | stat.abort_done | mode_uart;
    clr[IDX_ABRT] = stat.abort_done;
    clr[IDX_DTX]  = stat.rsp_done | stat.abort_done | stat.err | mode_uart;
    clr[IDX_DISC] = stat.idle | mode_uart;
    clr[IDX_WAKE] = stat.wake_done | stat.abort_done;
  end
endmodule

// File: rtl/lin_req_cfg.sv
module lin_req_cfg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic mode_init,
  input  logic par_err,
  output logic cfg_o,
  output logic to_idle_o
);
  logic cfg_r, cfg_d, cfg_en;

  assign cfg_en = wr_en & mode_init;

  always_comb begin
    cfg_d = cfg_r;
    if (cfg_en) cfg_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_r <= 1'b0;
    else        cfg_r <= cfg_d;
  end

  assign cfg_o     = cfg_r;
  assign to_idle_o = par_err & cfg_r;

  // R9: outside initialization mode the configuration holds
  a_r9_cfg_init_only: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_init |=> $stable(cfg_r));
endmodule

// File: rtl/lin_req_ack.sv
module lin_req_ack
  import lin_req_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  eng_stat_t       stat,
  input  logic [NREQ-1:0] q,
  output logic            ack_done_o,
  output logic            ack_abort_o
);
  logic fin, done_d, abrt_d, done_r, abrt_r;

  always_comb begin
    fin    = (stat.hdr_done  & q[IDX_HDR]) |
             (stat.rsp_done  & q[IDX_DTX]) |
             (stat.wake_done & q[IDX_WAKE]);
    abrt_d = stat.abort_done & (|q);
    done_d = fin & ~stat.abort_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_r <= 1'b0;
      abrt_r <= 1'b0;
    end else begin
      done_r <= done_d;
      abrt_r <= abrt_d;
    end
  end

  assign ack_done_o  = done_r;
  assign ack_abort_o = abrt_r;

  // R11: abort acknowledge follows an abort strobe
  a_r11_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
    abrt_r |-> $past(stat.abort_done));
  // R11: never both acknowledges together
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_r && abrt_r));
endmodule

// File: rtl/lin_req_ctrl.sv
module lin_req_ctrl
  import lin_req_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              mode_init,
  input  logic              mode_sleep,
  input  logic              mode_master,
  input  logic              mode_uart,
  input  logic              hdr_rcvd,
  input  logic              id_match,
  input  logic              buf_dir_tx,
  input  logic [DATA_W-1:0] buf_data0,
  input  logic              eng_hdr_done,
  input  logic              eng_rsp_done,
  input  logic              eng_abort_done,
  input  logic              eng_err,
  input  logic              eng_idle,
  input  logic              eng_wake_done,
  input  logic              eng_par_err,
  output logic [REG_W-1:0]  rd_data,
  output logic              cmd_hdr,
  output logic              cmd_abort,
  output logic              cmd_dtx,
  output logic              cmd_discard,
  output logic              cmd_wake,
  output logic [DATA_W-1:0] wake_char,
  output logic              bit_chk_en,
  output logic              fsm_to_idle,
  output logic              ack_done,
  output logic              ack_abort
);
  eng_stat_t       stat;
  logic [NREQ-1:0] q, cmd, set, clr;
  logic            cfg;
  logic [DATA_W-1:0] wchar_r, wchar_d;
  logic            wchar_en;

  assign stat = '{hdr_done:   eng_hdr_done,
                  rsp_done:   eng_rsp_done,
                  abort_done: eng_abort_done,
                  err:        eng_err,
                  idle:       eng_idle,
                  wake_done:  eng_wake_done};

  lin_req_rules i_rules (
    .wr_en       (wr_en),
    .wr_req      (wr_data[NREQ-1:0]),
    .mode_sleep  (mode_sleep),
    .mode_master (mode_master),
    .mode_uart   (mode_uart),
    .hdr_rcvd    (hdr_rcvd),
    .id_match    (id_match),
    .buf_dir_tx  (buf_dir_tx),
    .stat        (stat),
    .q           (q),
    .set         (set),
    .clr         (clr)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    lin_req_bit i_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set[g]),
      .clr_i (clr[g]),
      .q_o   (q[g]),
      .cmd_o (cmd[g])
    );
  end

  lin_req_cfg i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_val    (wr_data[IDX_PCFG]),
    .mode_init (mode_init),
    .par_err   (eng_par_err),
    .cfg_o     (cfg),
    .to_idle_o (fsm_to_idle)
  );

  lin_req_ack i_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .stat        (stat),
    .q           (q),
    .ack_done_o  (ack_done),
    .ack_abort_o (ack_abort)
  );

  assign wchar_en = set[IDX_WAKE] & ~clr[IDX_WAKE] & ~q[IDX_WAKE];

  always_comb begin
    wchar_d = wchar_r;
    if (wchar_en) wchar_d = buf_data0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wchar_r <= '0;
    else        wchar_r <= wchar_d;
  end

  assign rd_data     = {cfg, q};
  assign cmd_hdr     = cmd[IDX_HDR];
  assign cmd_abort   = cmd[IDX_ABRT];
  assign cmd_dtx     = cmd[IDX_DTX];
  assign cmd_discard = cmd[IDX_DISC];
  assign cmd_wake    = cmd[IDX_WAKE];
  assign wake_char   = wchar_r;
  assign bit_chk_en  = ~q[IDX_WAKE];

  // R3: UART mode keeps the frame requests clear
  a_r3_uart_holds_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_uart |=> !(q[IDX_HDR] || q[IDX_DTX] || q[IDX_DISC]));
  // R4: slave data send only after a received header
  a_r4_slave_dtx_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(q[IDX_DTX]) && !$past(mode_master)) |-> $past(hdr_rcvd));
  // R7: no wake-up accepted in sleep
  a_r7_no_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q[IDX_WAKE]) |-> !$past(mode_sleep));
  // R8: abort completion empties the transmit-side requests
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eng_abort_done |=> !(q[IDX_HDR] || q[IDX_DTX] || q[IDX_WAKE] || q[IDX_ABRT]));
  // R10: return to idle only on a parity error
  a_r10_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fsm_to_idle |-> eng_par_err);
endmodule

// File: tb/test_lin_req_ctrl.sv
module test_lin_req_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0] wd;
    logic       wr;
    logic [3:0] md;   // init, sleep, master, uart
    logic       hr;
    logic       im;
    logic [6:0] st;   // par_err, wake_done, idle, err, abort_done, rsp_done, hdr_done
    logic [5:0] exp;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{6'b000001,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b000001}, // R3 set header
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0000001,6'b000000}, // R3 header done
    '{6'b000100,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b000000}, // R4 no header flag
    '{6'b000100,1'b1,4'b0000,1'b1,1'b0,7'b0000000,6'b000100}, // R4 accepted
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0001000,6'b000000}, // R4 error clears
    '{6'b001000,1'b1,4'b0000,1'b1,1'b1,7'b0000000,6'b000000}, // R6 filter matched
    '{6'b001000,1'b1,4'b0000,1'b1,1'b0,7'b0000000,6'b001000}, // R6 accepted
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0010000,6'b000000}, // R6 idle clears
    '{6'b000001,1'b1,4'b0010,1'b0,1'b0,7'b0000000,6'b000001}, // R5 master header
    '{6'b000000,1'b0,4'b0010,1'b0,1'b0,7'b0000001,6'b000100}, // R5 hw data send
    '{6'b000000,1'b0,4'b0010,1'b0,1'b0,7'b0000010,6'b000000}, // R5 response done
    '{6'b000100,1'b1,4'b0010,1'b1,1'b0,7'b0000000,6'b000000}, // R5 sw write ignored
    '{6'b010000,1'b1,4'b0100,1'b0,1'b0,7'b0000000,6'b000000}, // R7 sleep ignores
    '{6'b010000,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b010000}, // R7 wake accepted
    '{6'b000010,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b010010}, // R8 abort set
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0000100,6'b000000}, // R8 abort clears wake
    '{6'b000001,1'b1,4'b0001,1'b0,1'b0,7'b0000000,6'b000000}, // R3 uart ignores header
    '{6'b000010,1'b1,4'b0001,1'b0,1'b0,7'b0000000,6'b000010}, // R8 abort in uart
    '{6'b000000,1'b0,4'b0001,1'b0,1'b0,7'b0000100,6'b000000}, // R8 abort done
    '{6'b100000,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b000000}, // R9 not init
    '{6'b100000,1'b1,4'b1000,1'b0,1'b0,7'b0000000,6'b100000}, // R9 init writes 1
    '{6'b000000,1'b1,4'b1000,1'b0,1'b0,7'b0000000,6'b000000}, // R9 init writes 0
    '{6'b000001,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b000001}, // R2 set
    '{6'b000000,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b000001}, // R2 zero write ignored
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0000001,6'b000000}, // R2 hw clear
    '{6'b010000,1'b1,4'b0000,1'b0,1'b0,7'b0000000,6'b010000}, // R7 wake again
    '{6'b000000,1'b0,4'b0000,1'b0,1'b0,7'b0100000,6'b000000}  // R7 wake done
  };

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [5:0] wr_data;
  logic mode_init, mode_sleep, mode_master, mode_uart;
  logic hdr_rcvd, id_match, buf_dir_tx;
  logic [7:0] buf_data0;
  logic eng_hdr_done, eng_rsp_done, eng_abort_done, eng_err, eng_idle, eng_wake_done, eng_par_err;
  logic [5:0] rd_data;
  logic cmd_hdr, cmd_abort, cmd_dtx, cmd_discard, cmd_wake;
  logic [7:0] wake_char;
  logic bit_chk_en, fsm_to_idle, ack_done, ack_abort;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_req_ctrl i_lin_req_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_init(mode_init), .mode_sleep(mode_sleep), .mode_master(mode_master),
    .mode_uart(mode_uart), .hdr_rcvd(hdr_rcvd), .id_match(id_match),
    .buf_dir_tx(buf_dir_tx), .buf_data0(buf_data0),
    .eng_hdr_done(eng_hdr_done), .eng_rsp_done(eng_rsp_done),
    .eng_abort_done(eng_abort_done), .eng_err(eng_err), .eng_idle(eng_idle),
    .eng_wake_done(eng_wake_done), .eng_par_err(eng_par_err),
    .rd_data(rd_data), .cmd_hdr(cmd_hdr), .cmd_abort(cmd_abort), .cmd_dtx(cmd_dtx),
    .cmd_discard(cmd_discard), .cmd_wake(cmd_wake), .wake_char(wake_char),
    .bit_chk_en(bit_chk_en), .fsm_to_idle(fsm_to_idle),
    .ack_done(ack_done), .ack_abort(ack_abort)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    wr_en = 0; wr_data = '0;
    mode_init = 0; mode_sleep = 0; mode_master = 0; mode_uart = 0;
    hdr_rcvd = 0; id_match = 0; buf_dir_tx = 1;
    eng_hdr_done = 0; eng_rsp_done = 0; eng_abort_done = 0;
    eng_err = 0; eng_idle = 0; eng_wake_done = 0; eng_par_err = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_vec(input vec_t v);
    wr_data = v.wd; wr_en = v.wr;
    {mode_init, mode_sleep, mode_master, mode_uart} = v.md;
    hdr_rcvd = v.hr; id_match = v.im;
    {eng_par_err, eng_wake_done, eng_idle, eng_err,
     eng_abort_done, eng_rsp_done, eng_hdr_done} = v.st;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    idle_in();
    buf_data0 = 8'h00;
    rst_n = 0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd_data, 0);
    chk("R1 cmds", {cmd_hdr, cmd_abort, cmd_dtx, cmd_discard, cmd_wake, ack_done, ack_abort}, 0);
    rst_n = 1;
    tick();

    for (int i = 0; i < NV; i++) begin
      put_vec(VEC[i]);
      tick();
      chk($sformatf("vec%0d rd", i), rd_data, VEC[i].exp);
    end
    idle_in();
    tick();

    // R2 command pulse lasts one cycle
    wr_en = 1; wr_data = 6'b000001;
    tick();
    wr_en = 0; wr_data = '0;
    chk("R2 cmd_hdr high", cmd_hdr, 1);
    tick();
    chk("R2 cmd_hdr low", cmd_hdr, 0);
    chk("R2 still set", rd_data, 6'b000001);

    // R11 completion and abort together
    eng_hdr_done = 1; eng_abort_done = 1;
    tick();
    eng_hdr_done = 0; eng_abort_done = 0;
    chk("R11 ack_abort", ack_abort, 1);
    chk("R11 ack_done", ack_done, 0);
    chk("R11 cleared", rd_data, 0);

    // R11 completion alone
    wr_en = 1; wr_data = 6'b000001;
    tick();
    wr_en = 0; wr_data = '0;
    eng_hdr_done = 1;
    tick();
    eng_hdr_done = 0;
    chk("R11 ack_done alone", ack_done, 1);
    chk("R11 ack_abort alone", ack_abort, 0);

    // R5 master with receive direction: no data send
    mode_master = 1; buf_dir_tx = 0;
    wr_en = 1; wr_data = 6'b000001;
    tick();
    wr_en = 0; wr_data = '0;
    eng_hdr_done = 1;
    tick();
    eng_hdr_done = 0;
    chk("R5 dir rx no dtx", rd_data, 0);
    mode_master = 0; buf_dir_tx = 1;

    // R7 wake character capture and bit check
    buf_data0 = 8'hA5;
    wr_en = 1; wr_data = 6'b010000;
    tick();
    wr_en = 0; wr_data = '0;
    chk("R7 cmd_wake", cmd_wake, 1);
    buf_data0 = 8'h3C;
    tick();
    chk("R7 wake_char held", wake_char, 8'hA5);
    chk("R7 bit check off", bit_chk_en, 0);
    eng_wake_done = 1;
    tick();
    eng_wake_done = 0;
    chk("R7 bit check on", bit_chk_en, 1);

    // R10 parity response
    eng_par_err = 1;
    #1 chk("R10 cfg0 no idle", fsm_to_idle, 0);
    eng_par_err = 0;
    mode_init = 1; wr_en = 1; wr_data = 6'b100000;
    tick();
    mode_init = 0; wr_en = 0; wr_data = '0;
    eng_par_err = 1;
    #1 chk("R10 cfg1 idle", fsm_to_idle, 1);
    eng_par_err = 0;
    tick();

    // R1 reset mid-run clears everything
    wr_en = 1; wr_data = 6'b000011;
    tick();
    wr_en = 0; wr_data = '0;
    rst_n = 0;
    #1 chk("R1 async reset", rd_data, 0);
    tick();
    rst_n = 1;
    tick();
    chk("R1 after reset", rd_data, 0);

    report();
  end
endmodule